// File: doc/BRIEF.md
# Calendar-Driven Port Poll Sequencer

This block walks a fixed calendar of transmit ports in round-robin order. While a port is selected, it shows that port's identifier and raises a read strobe, together with a one-hot select for the buffer bank that the port is mapped to. The strobe stays up for the port's programmed burst length. Each bank has a link-disable input. A port whose bank is disabled drops out of the rotation while the sequencer runs.

A skipped calendar entry is not free. Each one costs a fixed two idle cycles. During those cycles no bank is read and the identifier output keeps the last port that was read. The poll period is therefore the sum of the bursts of the enabled ports plus two cycles for every skipped entry. Disabling a port shortens the period by its burst minus two cycles, not by the full burst.

The disable inputs are looked at only when the sequencer moves from one calendar entry to the next. A burst that has started always runs to its end.

Top module: `poll_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `portId` is 0, `rdEn` is 0 and `bankSel` is 0. Reset returns the sequencer to calendar entry 0 with its burst counter cleared. If port 0 is enabled, its burst starts in the second cycle after release.
- R2: With no bank disabled and every burst set to 4, the ports are read in the order 0, 1, 2, 3, 0, ... Each port holds `rdEn` high for 4 consecutive cycles, which gives a period of 16 cycles.
- R3: Port p takes its burst length from `burstLen[p*4 +: 4]`. A burst value of 0 acts as 1.
- R4: A port is skipped when `linkDis[b]` is 1, where b is the bank it is mapped to. Each skipped entry adds 2 cycles in which `rdEn` is 0, `bankSel` is 0 and `portId` keeps the last port that was read. For example, with bank 1 disabled the order is 0, 2, 3, and port 0 shows for 6 cycles.
- R5: Skip penalties add up. With banks 1 and 2 disabled, port 0's burst is followed by 4 idle cycles, and the poll period is 12 cycles.
- R6: Port p is mapped to the bank given by `portBank[p*2 +: 2]`. During a read, `bankSel` is the one-hot code of that bank. `portId` changes only in a cycle in which `rdEn` is high.
- R7: A change on `linkDis` is sampled at the next calendar transition. A burst that is already in progress always completes its full length.
- R8: When every bank is disabled, `rdEn` stays at 0 for as long as that lasts. After a disable is released, the first port mapped to an enabled bank starts its burst within 9 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burstLen | input | NUM_PORTS*BURST_W | Burst length of each port; port p at [p*BURST_W +: BURST_W] |
| portBank | input | NUM_PORTS*BANK_W | Bank of each port; port p at [p*BANK_W +: BANK_W] |
| linkDis | input | NUM_BANKS | Link disable for each bank, 1 = disabled |
| portId | output | ID_W | Identifier of the port being polled, or of the last port read |
| rdEn | output | 1 | Read strobe to the selected bank |
| bankSel | output | NUM_BANKS | One-hot select of the bank being read, all zero when idle |

## Verification
The hardest case to reach is a disable that changes in the middle of a burst. The bench raises `linkDis` for the port being polled two cycles into its burst. It then checks that the burst still runs its full length and that the port is dropped only on the next lap, at the cycle predicted by the 2-cycle penalty. A second hard case is the all-disabled state. The bench enters it straight out of reset, which makes even entry 0 a skip. It then frees a single bank and checks that the sequencer resumes at exactly that bank's port, whatever point of the calendar it had reached.

// File: rtl/poll_seq_pkg.sv
package poll_seq_pkg;

  typedef enum logic [1:0] {
    SQ_LAUNCH = 2'd0,
    SQ_READ   = 2'd1,
    SQ_SKIP   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic advance;   // step to the next calendar entry
    logic cntClr;    // restart the burst counter
    logic cntInc;    // count one burst beat
    logic idLoad;    // publish the target entry on the ID output
    logic rdActive;  // a bank is being read this cycle
  } strobe_t;

endpackage

// File: rtl/poll_seq_ctrl.sv
module poll_seq_ctrl
  import poll_seq_pkg::*;
#(
  parameter int SKIP_CYC = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    curEn,
  input  logic    nextEn,
  input  logic    burstDone,
  output strobe_t st
);

  localparam int SKIP_W = (SKIP_CYC > 1) ? $clog2(SKIP_CYC) : 1;
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(SKIP_CYC - 1);

  seqState_t state, nxtState;
  logic [SKIP_W-1:0] skipCnt, nxtSkip;

  always_comb begin
    nxtState    = state;
    nxtSkip     = skipCnt;
    st          = '0;
    st.rdActive = (state == SQ_READ);
    case (state)
      SQ_LAUNCH: begin
        if (curEn) begin
          nxtState  = SQ_READ;
          st.cntClr = 1'b1;
          st.idLoad = 1'b1;
        end else begin
          nxtState = SQ_SKIP;
          nxtSkip  = '0;
        end
      end
      SQ_READ: begin
        if (burstDone) begin
          st.advance = 1'b1;
          if (nextEn) begin
            st.cntClr = 1'b1;
            st.idLoad = 1'b1;
          end else begin
            nxtState = SQ_SKIP;
            nxtSkip  = '0;
          end
        end else begin
          st.cntInc = 1'b1;
        end
      end
      SQ_SKIP: begin
        if (skipCnt == SKIP_LAST) begin
          st.advance = 1'b1;
          nxtSkip    = '0;
          if (nextEn) begin
            nxtState  = SQ_READ;
            st.cntClr = 1'b1;
            st.idLoad = 1'b1;
          end
        end else begin
          nxtSkip = skipCnt + 1'b1;
        end
      end
      default: nxtState = SQ_LAUNCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_LAUNCH;
      skipCnt <= '0;
    end else begin
      state   <= nxtState;
      skipCnt <= nxtSkip;
    end
  end

endmodule

// File: rtl/poll_seq_dp.sv
module poll_seq_dp
  import poll_seq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_BANKS = 4,
  parameter int BURST_W   = 4,
  parameter int ID_W      = 8,
  localparam int IDX_W    = $clog2(NUM_PORTS),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       st,
  input  logic [NUM_PORTS*BURST_W-1:0]  burstLen,
  input  logic [NUM_PORTS*BANK_W-1:0]   portBank,
  input  logic [NUM_BANKS-1:0]          linkDis,
  output logic                          curEn,
  output logic                          nextEn,
  output logic                          burstDone,
  output logic [ID_W-1:0]               portId,
  output logic                          rdEn,
  output logic [NUM_BANKS-1:0]          bankSel
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

  logic [IDX_W-1:0]   entry, nextIdx, tgtIdx, idReg;
  logic [BURST_W-1:0] cnt, curBurst;
  logic [BURST_W:0]   beatCount;
  logic [BANK_W-1:0]  curBank, nextBank;

  assign nextIdx  = (entry == LAST_IDX) ? '0 : entry + 1'b1;
  assign tgtIdx   = st.advance ? nextIdx : entry;
  assign curBurst = burstLen[entry*BURST_W +: BURST_W];
  assign curBank  = portBank[entry*BANK_W +: BANK_W];
  assign nextBank = portBank[nextIdx*BANK_W +: BANK_W];

  assign curEn  = ~linkDis[curBank];
  assign nextEn = ~linkDis[nextBank];

  // A burst value of zero still yields one beat.
  assign beatCount = {1'b0, cnt} + (BURST_W+1)'(1);
  assign burstDone = (beatCount >= {1'b0, curBurst});

  always_ff @(posedge clk) begin
    if (rst) begin
      entry <= '0;
      cnt   <= '0;
      idReg <= '0;
    end else begin
      if (st.advance) entry <= nextIdx;
      if (st.cntClr)      cnt <= '0;
      else if (st.cntInc) cnt <= cnt + 1'b1;
      if (st.idLoad) idReg <= tgtIdx;
    end
  end

  assign portId = ID_W'(idReg);
  assign rdEn   = st.rdActive;

  always_comb begin
    bankSel = '0;
    if (st.rdActive) bankSel[curBank] = 1'b1;
  end

endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import poll_seq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_BANKS = 4,
  parameter int BURST_W   = 4,
  parameter int ID_W      = 8,
  parameter int SKIP_CYC  = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS*BURST_W-1:0]  burstLen,
  input  logic [NUM_PORTS*BANK_W-1:0]   portBank,
  input  logic [NUM_BANKS-1:0]          linkDis,
  output logic [ID_W-1:0]               portId,
  output logic                          rdEn,
  output logic [NUM_BANKS-1:0]          bankSel
);

  strobe_t st;
  logic curEn, nextEn, burstDone;

  poll_seq_ctrl #(.SKIP_CYC(SKIP_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .curEn(curEn), .nextEn(nextEn),
    .burstDone(burstDone), .st(st)
  );

  poll_seq_dp #(
    .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS),
    .BURST_W(BURST_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rst(rst), .st(st), .burstLen(burstLen),
    .portBank(portBank), .linkDis(linkDis), .curEn(curEn),
    .nextEn(nextEn), .burstDone(burstDone), .portId(portId),
    .rdEn(rdEn), .bankSel(bankSel)
  );

endmodule

// File: rtl/poll_seq_chk.sv
module poll_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ID_W      = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] linkDis,
  input logic [ID_W-1:0]      portId,
  input logic                 rdEn,
  input logic [NUM_BANKS-1:0] bankSel
);

  // R6: exactly one bank is selected while reading
  a_r6_one_bank: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> ($countones(bankSel) == 1));

  // R6: the identifier moves only when a read is under way
  a_r6_id_moves_on_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(portId)) |-> rdEn);

  // R4: a skip gap lasts at least two cycles
  a_r4_skip_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(rdEn) && !$past(rst)) |=> !rdEn);

  // R8: no read can start while every bank is disabled
  a_r8_all_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (&linkDis) && (&$past(linkDis)) && !$past(rdEn)) |-> !rdEn);

endmodule

bind poll_seq poll_seq_chk #(.NUM_BANKS(NUM_BANKS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .linkDis(linkDis), .portId(portId),
  .rdEn(rdEn), .bankSel(bankSel)
);

// File: tb/poll_seq_tb.sv
`timescale 1ns/100ps
module poll_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] burstLen = 16'h4444;
  logic [7:0]  portBank = 8'hE4;
  logic [3:0]  linkDis  = 4'h0;
  logic [7:0]  portId;
  logic        rdEn;
  logic [3:0]  bankSel;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  poll_seq u_dut (
    .clk(clk), .rst(rst), .burstLen(burstLen), .portBank(portBank),
    .linkDis(linkDis), .portId(portId), .rdEn(rdEn), .bankSel(bankSel)
  );

  // {rdEn, portId[1:0]} per cycle, bank 1 disabled, bursts of 4 (R4, R2)
  localparam logic [2:0] VEC [28] = '{
    3'd4, 3'd4, 3'd4, 3'd4, 3'd0, 3'd0, 3'd6, 3'd6, 3'd6, 3'd6,
    3'd7, 3'd7, 3'd7, 3'd7,
    3'd4, 3'd4, 3'd4, 3'd4, 3'd0, 3'd0, 3'd6, 3'd6, 3'd6, 3'd6,
    3'd7, 3'd7, 3'd7, 3'd7
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic er, input logic [7:0] eid,
                     input logic [3:0] eb);
    nVec++;
    if (rdEn !== er || portId !== eid || bankSel !== eb) begin
      nBad++;
      $display("FAIL %s: rdEn/portId/bankSel = %0b/%0d/%b, expected %0b/%0d/%b",
               tag, rdEn, portId, bankSel, er, eid, eb);
    end
  endtask

  // Checks n consecutive cycles, stepping after each.
  task automatic seg(input string tag, input logic er, input logic [7:0] eid,
                     input logic [3:0] eb, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, er, eid, eb);
      step();
    end
  endtask

  task automatic startRun(input logic [15:0] bl, input logic [7:0] map,
                          input logic [3:0] dis);
    @(negedge clk);
    burstLen = bl;
    portBank = map;
    linkDis  = dis;
    rst      = 1'b1;
    step();
    step();
    chk("R1 in reset", 1'b0, 8'd0, 4'b0000);
    rst = 1'b0;
    chk("R1 launch cycle", 1'b0, 8'd0, 4'b0000);
    step();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    // Table walk: bank 1 disabled (R4)
    startRun(16'h4444, 8'hE4, 4'b0010);
    for (int i = 0; i < 28; i++) begin
      chk("R4 table", VEC[i][2], {6'd0, VEC[i][1:0]},
          VEC[i][2] ? (4'b0001 << VEC[i][1:0]) : 4'b0000);
      step();
    end

    // R2: plain round robin, period 16
    startRun(16'h4444, 8'hE4, 4'b0000);
    for (int r = 0; r < 8; r++)
      seg("R2 round robin", 1'b1, 8'(r % 4), 4'b0001 << (r % 4), 4);

    // R5: two disabled banks, 4 idle cycles, period 12
    startRun(16'h4444, 8'hE4, 4'b0110);
    for (int r = 0; r < 2; r++) begin
      seg("R5 port0", 1'b1, 8'd0, 4'b0001, 4);
      seg("R5 double skip", 1'b0, 8'd0, 4'b0000, 4);
      seg("R5 port3", 1'b1, 8'd3, 4'b1000, 4);
    end

    // R3: per-port bursts 2,0(->1),3,1
    startRun(16'h1302, 8'hE4, 4'b0000);
    for (int r = 0; r < 2; r++) begin
      seg("R3 burst2", 1'b1, 8'd0, 4'b0001, 2);
      seg("R3 burst0", 1'b1, 8'd1, 4'b0010, 1);
      seg("R3 burst3", 1'b1, 8'd2, 4'b0100, 3);
      seg("R3 burst1", 1'b1, 8'd3, 4'b1000, 1);
    end

    // R6: reversed map, bank 2 disabled removes port 1
    startRun(16'h4444, 8'h1B, 4'b0100);
    seg("R6 port0 bank3", 1'b1, 8'd0, 4'b1000, 4);
    seg("R6 skip", 1'b0, 8'd0, 4'b0000, 2);
    seg("R6 port2 bank1", 1'b1, 8'd2, 4'b0010, 4);
    seg("R6 port3 bank0", 1'b1, 8'd3, 4'b0001, 2);

    // R7: disable port 1's bank in mid burst; R1 reset mid-run above
    startRun(16'h4444, 8'hE4, 4'b0000);
    seg("R7 port0", 1'b1, 8'd0, 4'b0001, 4);
    seg("R7 port1 head", 1'b1, 8'd1, 4'b0010, 2);
    linkDis = 4'b0010;
    seg("R7 port1 tail", 1'b1, 8'd1, 4'b0010, 2);
    seg("R7 port2", 1'b1, 8'd2, 4'b0100, 4);
    seg("R7 port3", 1'b1, 8'd3, 4'b1000, 4);
    seg("R7 port0 again", 1'b1, 8'd0, 4'b0001, 4);
    seg("R7 skip port1", 1'b0, 8'd0, 4'b0000, 2);
    seg("R7 port2 again", 1'b1, 8'd2, 4'b0100, 1);

    // R8: all disabled, then free bank 2 only
    startRun(16'h4444, 8'hE4, 4'b1111);
    seg("R8 all disabled", 1'b0, 8'd0, 4'b0000, 40);
    linkDis = 4'b1011;
    begin
      int waited;
      waited = 0;
      while (rdEn !== 1'b1 && waited < 9) begin
        step();
        waited++;
      end
      chk("R8 resume at port2", 1'b1, 8'd2, 4'b0100);
    end

    finishRun();
  end

endmodule